// File: doc/BRIEF.md
# Colour Channel Multiplexer Sequencer

This block produces the two-bit colour select that steers one of three colour inputs (red, green, blue) into a single shared converter. It runs on the converter clock. In normal operation it visits red, then green, then blue, one colour per clock, so that three conversions make up one pixel. An active-low start-of-line input puts the sequence back to red. A configuration-driven single-colour mode fixes the select to one chosen colour. An active-low external override takes the colour from two external pins and wins over both other sources.

The converter delivers each result a fixed number of clocks after its sample is taken. The block therefore also outputs a colour tag that has passed through a delay line of the same length, together with a valid strobe. Logic downstream can then label every result with the colour it came from. A reserved colour code from whichever source is active is replaced by red, and it sets a sticky error flag.

The sequencer is built from four named states. `SQ_LINE` is line start: it selects red while start-of-line is asserted. `SQ_RED`, `SQ_GREEN` and `SQ_BLUE` form the rotation. On a rising edge with start-of-line low, every state goes to `SQ_LINE`. With start-of-line high, the rotation edges run `SQ_LINE`→`SQ_RED`→`SQ_GREEN`→`SQ_BLUE`→`SQ_RED`.

Top module: `colour_mux_seq`

## Requirements
- R1: While reset is asserted and straight after it, the select is red (00), the tag is 00, the tag valid strobe is 0 and the error flag is 0.
- R2: A rising edge that samples start-of-line low moves the sequencer to line start, and the select is red in the following cycle. It stays red for as long as start-of-line is still sampled low.
- R3: With start-of-line high, the first edge that leaves line start keeps red. Each later edge advances red→green (01)→blue (10)→red.
- R4: When single-colour mode is enabled and the override is inactive, the select equals the configured colour code (00 red, 01 green, 10 blue) on every cycle and does not rotate.
- R5: When the active-low override input is 0, the select equals the external colour code (00 red, 01 green, 10 blue). This takes priority over single-colour mode and over rotation.
- R6: A reserved code (11) from the active source drives the select to red. The select never shows 11.
- R7: The error flag becomes 1 on the edge that ends a cycle in which a reserved code was selected, and it stays 1 until reset. A reserved code on an inactive source leaves it at 0.
- R8: With the default latency of 4, the tag in cycle c+4 equals the select in cycle c, where cycle 0 is the first cycle after reset is released.
- R9: The tag valid strobe is 0 in the first 4 cycles after reset and 1 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sol_n | input | 1 | Start-of-line, active low, sampled on rising edges |
| single_en | input | 1 | Single-colour mode enable from configuration |
| single_colour | input | 2 | Configured colour for single-colour mode |
| ext_n | input | 1 | External override enable, active low |
| ext_colour | input | 2 | External colour code used under override |
| sel | output | 2 | Current colour select to the multiplexer |
| tag | output | 2 | Colour of the conversion result now leaving the converter |
| tag_valid | output | 1 | Tag path has filled since reset |
| reserved_err | output | 1 | Sticky flag: a reserved colour code was selected |

## Verification
Some properties are checked by assertions on every cycle. After a low start-of-line the sequencer is at line start. Red is followed by green under a high start-of-line. The select never carries the reserved code. The error flag and the valid strobe never fall. Each tag stage holds the previous value of the stage before it.

Other behaviour shows only in the bench scenarios, because it depends on how the sources combine across whole sequences. These are the exact rotation phase after a pulse of start-of-line or a held one, and the priority of the override over single-colour mode. They also cover the point where the error flag sets, and that a reserved code on an inactive source does nothing. Finally, the bench checks that each tag matches the select from four cycles earlier. It does this with a queue of expected selects.

// File: rtl/cmux_pkg.sv
package cmux_pkg;

    localparam int COLOUR_W = 2;

    typedef enum logic [COLOUR_W-1:0] {
        CLR_RED   = 2'b00,
        CLR_GREEN = 2'b01,
        CLR_BLUE  = 2'b10,
        CLR_RSVD  = 2'b11
    } colour_e;

    typedef enum logic [1:0] {
        SQ_LINE,
        SQ_RED,
        SQ_GREEN,
        SQ_BLUE
    } seq_state_e;

endpackage

// File: rtl/cmux_rotor.sv
module cmux_rotor
    import cmux_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sol_n,
    output logic [COLOUR_W-1:0] rot_colour
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state: line start on low start-of-line, otherwise rotate.
    always_comb begin
        state_d = state_q;
        if (!sol_n) begin
            state_d = SQ_LINE;
        end else begin
            unique case (state_q)
                SQ_LINE:  state_d = SQ_RED;
                SQ_RED:   state_d = SQ_GREEN;
                SQ_GREEN: state_d = SQ_BLUE;
                SQ_BLUE:  state_d = SQ_RED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_LINE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: line start and red both select red.
    always_comb begin
        rot_colour = CLR_RED;
        unique case (state_q)
            SQ_LINE:  rot_colour = CLR_RED;
            SQ_RED:   rot_colour = CLR_RED;
            SQ_GREEN: rot_colour = CLR_GREEN;
            SQ_BLUE:  rot_colour = CLR_BLUE;
        endcase
    end

    a_r2_line_after_sol: assert property (
        @(posedge clk) disable iff (!rst_n)
        !sol_n |=> (state_q == SQ_LINE)
    ) else $error("a_r2_line_after_sol");

    a_r3_red_to_green: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RED && sol_n) |=> (state_q == SQ_GREEN)
    ) else $error("a_r3_red_to_green");

    a_r3_line_keeps_red: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == SQ_LINE && sol_n) |=> (rot_colour == CLR_RED)
    ) else $error("a_r3_line_keeps_red");

endmodule

// File: rtl/cmux_select.sv
module cmux_select
    import cmux_pkg::*;
(
    input  logic [COLOUR_W-1:0] rot_colour,
    input  logic                single_en,
    input  logic [COLOUR_W-1:0] single_colour,
    input  logic                ext_n,
    input  logic [COLOUR_W-1:0] ext_colour,
    output logic [COLOUR_W-1:0] sel,
    output logic                reserved_hit
);

    logic [COLOUR_W-1:0] raw;

    // Source priority: external override, then single mode, then rotation.
    always_comb begin
        if (!ext_n) begin
            raw = ext_colour;
        end else if (single_en) begin
            raw = single_colour;
        end else begin
            raw = rot_colour;
        end
    end

    always_comb begin
        reserved_hit = 1'b0;
        sel          = CLR_RED;
        unique case (raw)
            CLR_RED:   sel = CLR_RED;
            CLR_GREEN: sel = CLR_GREEN;
            CLR_BLUE:  sel = CLR_BLUE;
            CLR_RSVD: begin
                sel          = CLR_RED;
                reserved_hit = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cmux_tag_pipe.sv
module cmux_tag_pipe #(
    parameter int LATENCY = 4,
    parameter int WIDTH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid
);

    localparam int LAST = LATENCY - 1;

    logic [WIDTH-1:0] stg [LATENCY];
    logic [LATENCY-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
            vld[0] <= 1'b0;
        end else begin
            stg[0] <= din;
            vld[0] <= 1'b1;
        end
    end

    for (genvar i = 1; i < LATENCY; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[i] <= '0;
                vld[i] <= 1'b0;
            end else begin
                stg[i] <= stg[i-1];
                vld[i] <= vld[i-1];
            end
        end

        a_r8_stage_shift: assert property (
            @(posedge clk) disable iff (!rst_n)
            1'b1 |=> (stg[i] == $past(stg[i-1]))
        ) else $error("a_r8_stage_shift");
    end

    assign dout       = stg[LAST];
    assign dout_valid = vld[LAST];

    a_r9_valid_stays: assert property (
        @(posedge clk) disable iff (!rst_n)
        dout_valid |=> dout_valid
    ) else $error("a_r9_valid_stays");

endmodule

// File: rtl/colour_mux_seq.sv
module colour_mux_seq
    import cmux_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sol_n,
    input  logic                single_en,
    input  logic [COLOUR_W-1:0] single_colour,
    input  logic                ext_n,
    input  logic [COLOUR_W-1:0] ext_colour,
    output logic [COLOUR_W-1:0] sel,
    output logic [COLOUR_W-1:0] tag,
    output logic                tag_valid,
    output logic                reserved_err
);

    logic [COLOUR_W-1:0] rot_colour;
    logic                reserved_hit;
    logic                err_q;

    cmux_rotor u_rotor (
        .clk        (clk),
        .rst_n      (rst_n),
        .sol_n      (sol_n),
        .rot_colour (rot_colour)
    );

    cmux_select u_select (
        .rot_colour    (rot_colour),
        .single_en     (single_en),
        .single_colour (single_colour),
        .ext_n         (ext_n),
        .ext_colour    (ext_colour),
        .sel           (sel),
        .reserved_hit  (reserved_hit)
    );

    cmux_tag_pipe #(
        .LATENCY (LATENCY),
        .WIDTH   (COLOUR_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (sel),
        .dout       (tag),
        .dout_valid (tag_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (reserved_hit) begin
            err_q <= 1'b1;
        end
    end

    assign reserved_err = err_q;

    a_r6_no_reserved_sel: assert property (
        @(posedge clk) disable iff (!rst_n)
        sel != CLR_RSVD
    ) else $error("a_r6_no_reserved_sel");

    a_r7_err_sticky: assert property (
        @(posedge clk) disable iff (!rst_n)
        reserved_err |=> reserved_err
    ) else $error("a_r7_err_sticky");

    a_r7_err_sets: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!ext_n && ext_colour == CLR_RSVD) |=> reserved_err
    ) else $error("a_r7_err_sets");

endmodule

// File: tb/sim_colour_mux_seq.sv
module sim_colour_mux_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sol_n = 1'b1;
    logic       single_en = 1'b0;
    logic [1:0] single_colour = 2'b00;
    logic       ext_n = 1'b1;
    logic [1:0] ext_colour = 2'b00;
    logic [1:0] sel;
    logic [1:0] tag;
    logic       tag_valid;
    logic       reserved_err;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 line start, 1 red, 2 green, 3 blue
    int m_state = 0;
    logic m_err = 1'b0;
    logic [1:0] exp_q [$];

    colour_mux_seq #(.LATENCY(LAT)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sol_n         (sol_n),
        .single_en     (single_en),
        .single_colour (single_colour),
        .ext_n         (ext_n),
        .ext_colour    (ext_colour),
        .sel           (sel),
        .tag           (tag),
        .tag_valid     (tag_valid),
        .reserved_err  (reserved_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver and scoreboard for one cycle; called just after a falling edge.
    task automatic step(input logic s_n, input logic s_en, input logic [1:0] s_col,
                        input logic e_n, input logic [1:0] e_col, input string req);
        logic [1:0] raw;
        logic [1:0] exp_sel;
        logic       res;
        sol_n = s_n; single_en = s_en; single_colour = s_col;
        ext_n = e_n; ext_colour = e_col;
        #1;
        if (!e_n)      raw = e_col;
        else if (s_en) raw = s_col;
        else           raw = (m_state == 2) ? 2'b01 : (m_state == 3) ? 2'b10 : 2'b00;
        res     = (raw == 2'b11);
        exp_sel = res ? 2'b00 : raw;
        chk(req, sel, exp_sel);
        chk("R7", reserved_err, m_err);
        if (exp_q.size() == LAT) begin
            chk("R8", tag, exp_q.pop_front());
            chk("R9", tag_valid, 1);
        end else begin
            chk("R9", tag_valid, 0);
        end
        exp_q.push_back(exp_sel);
        m_err = m_err | res;
        if (!s_n)              m_state = 0;
        else if (m_state == 3) m_state = 1;
        else                   m_state = m_state + 1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1", sel, 0);
        chk("R1", tag, 0);
        chk("R1", tag_valid, 0);
        chk("R1", reserved_err, 0);
        rst_n = 1'b1;
        // R3: free rotation from line start
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 2'b00, "R3");
        // R2: start-of-line held low two cycles, then rotation resumes
        step(1'b0, 1'b0, 2'b00, 1'b1, 2'b00, "R2");
        step(1'b0, 1'b0, 2'b00, 1'b1, 2'b00, "R2");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 2'b00, "R3");
        // R2: single-cycle pulse in mid rotation
        step(1'b0, 1'b0, 2'b00, 1'b1, 2'b00, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 2'b00, "R3");
        // R4: single-colour mode; reserved code on the inactive external pins
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'b01, 1'b1, 2'b11, "R4");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'b10, 1'b1, 2'b11, "R4");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 2'b00, 1'b1, 2'b11, "R4");
        // R5: override wins over single mode; reserved single code is inactive
        step(1'b1, 1'b1, 2'b11, 1'b0, 2'b01, "R5");
        step(1'b1, 1'b1, 2'b11, 1'b0, 2'b10, "R5");
        step(1'b1, 1'b1, 2'b10, 1'b0, 2'b00, "R5");
        step(1'b1, 1'b0, 2'b00, 1'b0, 2'b01, "R5");
        chk("R7", reserved_err, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 2'b00, "R3");
        // R6: reserved single code gives red and sets the flag
        step(1'b1, 1'b1, 2'b11, 1'b1, 2'b00, "R6");
        step(1'b1, 1'b1, 2'b11, 1'b1, 2'b00, "R6");
        // R6: reserved external code
        step(1'b1, 1'b0, 2'b00, 1'b0, 2'b11, "R6");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 2'b00, "R3");
        chk("R7", reserved_err, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule